// File: doc/BRIEF.md
# Segmented DAC Input Decoder

This block is the digital front end of an 8-bit segmented digital-to-analog converter. An 8-bit binary code enters together with an invert control and an active-low load strobe. The code is first optionally inverted bit by bit. It is then divided into two parts. The top three bits become a seven-line thermometer word, where an upper value of N lights the N lowest lines. The bottom five bits remain plain binary. Both parts are held in an output register bank that would steer the current-source array.

The storage works as a clocked equivalent of a feedthrough latch. While the strobe is low, the bank samples its inputs on every clock edge, so the outputs follow the input after one register stage. When the strobe goes high, the bank keeps the value it sampled at the last edge before that. A small sequencer names the mode the bank is in.

The states are ST_CLEAR (entered on reset, outputs zero), ST_TRACK (strobe low, sampling) and ST_HOLD (strobe high, frozen). The transitions are:

- ST_CLEAR→ST_TRACK or ST_CLEAR→ST_HOLD on the first edge after reset, following the strobe.
- ST_TRACK→ST_HOLD on the first edge that sees the strobe high.
- ST_HOLD→ST_TRACK on the first edge that sees the strobe low.
- Any state returns to ST_CLEAR when reset is asserted.

A combinational check output rebuilds the stored code from the two segments, so that the decode can be verified.

Top module: `sdac_input_decoder`

## Requirements
- R1: `code_chk` equals 32 times the number of ones in `therm_q`, plus `bin_q`.
- R2: With `invert` low, the stored code equals `code_in`. Bit 0 has weight 1 and bit 7 has weight 128.
- R3: With `invert` high, all eight bits of `code_in` are inverted before decoding and storage.
- R4: For an upper value N (bits 7..5 after inversion), `therm_q` has exactly bits 0..N-1 set.
- R5: `bin_q` equals bits 4..0 of the code after inversion.
- R6: While `load_n` is low, the outputs take the decoded input at the next rising clock edge. They do not change before that edge.
- R7: While `load_n` is high, the outputs are unchanged, whatever `code_in` and `invert` do.
- R8: When `load_n` rises, the outputs keep the value sampled at the last clock edge at which `load_n` was low.
- R9: An active-low reset `rst_n` clears `therm_q` and `bin_q` to zero, and so `code_chk` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_in | input | 8 | Binary code, bit 7 most significant |
| invert | input | 1 | Inverts all code bits when high |
| load_n | input | 1 | Load strobe, active low; high holds the outputs |
| therm_q | output | 7 | Stored thermometer word for the upper segment |
| bin_q | output | 5 | Stored binary word for the lower segment |
| code_chk | output | 8 | Code rebuilt from the stored segments |

## Verification
All 256 codes are applied with `invert` low and again with `invert` high. Each output is compared with an arithmetic expectation, which separates a wrong thermometer boundary from wrong lower bits and from a missing or partial inversion. Hold phases change the code and the invert control while the strobe is high, which exposes any leak through the bank. A strobe that rises together with a new code shows which edge's data is kept. Outputs are also sampled just before the edge, to confirm the one-stage latency.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_TRACK = 2'd1,
        ST_HOLD  = 2'd2
    } latch_state_e;
endpackage

// File: rtl/sdac_complement.sv
module sdac_complement #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              inv_i,
    output logic [DATA_W-1:0] data_o
);
    // each bit gated by the invert control
    for (genvar b = 0; b < DATA_W; b++) begin : g_xor
        assign data_o[b] = data_i[b] ^ inv_i;
    end
endmodule

// File: rtl/sdac_therm_enc.sv
module sdac_therm_enc #(
    parameter int SEG_BITS = 3,
    localparam int THERM_W = (1 << SEG_BITS) - 1
) (
    input  logic [SEG_BITS-1:0] seg_i,
    output logic [THERM_W-1:0]  therm_o
);
    // line i lights when the segment value exceeds i
    for (genvar i = 0; i < THERM_W; i++) begin : g_line
        assign therm_o[i] = (seg_i > SEG_BITS'(i));
    end
endmodule

// File: rtl/sdac_seg_latch.sv
module sdac_seg_latch
    import sdac_pkg::*;
#(
    parameter int THERM_W = 7,
    parameter int BIN_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n,
    input  logic [THERM_W-1:0] therm_d,
    input  logic [BIN_W-1:0]   bin_d,
    output logic [THERM_W-1:0] therm_q,
    output logic [BIN_W-1:0]   bin_q
);
    latch_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAR: state_nx = load_n ? ST_HOLD : ST_TRACK;
            ST_TRACK: state_nx = load_n ? ST_HOLD : ST_TRACK;
            ST_HOLD:  state_nx = load_n ? ST_HOLD : ST_TRACK;
            default:  state_nx = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CLEAR;
        else        state <= state_nx;
    end

    // output bank: samples while the strobe is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            therm_q <= '0;
            bin_q   <= '0;
        end else if (!load_n) begin
            therm_q <= therm_d;
            bin_q   <= bin_d;
        end
    end

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> ($stable(therm_q) && $stable(bin_q)));

    a_r6_track_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (therm_q == $past(therm_d) && bin_q == $past(bin_d)));

    a_r8_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> (state == ST_HOLD));
endmodule

// File: rtl/sdac_input_decoder.sv
module sdac_input_decoder #(
    parameter int DATA_W = 8,
    parameter int BIN_W  = 5,
    localparam int SEG_BITS = DATA_W - BIN_W,
    localparam int THERM_W  = (1 << SEG_BITS) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] code_in,
    input  logic              invert,
    input  logic              load_n,
    output logic [THERM_W-1:0] therm_q,
    output logic [BIN_W-1:0]   bin_q,
    output logic [DATA_W-1:0]  code_chk
);
    logic [DATA_W-1:0]  code_x;
    logic [THERM_W-1:0] therm_d;
    logic [SEG_BITS-1:0] ones;

    sdac_complement #(.DATA_W(DATA_W)) u_cmp (
        .data_i(code_in), .inv_i(invert), .data_o(code_x)
    );

    sdac_therm_enc #(.SEG_BITS(SEG_BITS)) u_enc (
        .seg_i(code_x[DATA_W-1:BIN_W]), .therm_o(therm_d)
    );

    sdac_seg_latch #(.THERM_W(THERM_W), .BIN_W(BIN_W)) u_lat (
        .clk(clk), .rst_n(rst_n), .load_n(load_n),
        .therm_d(therm_d), .bin_d(code_x[BIN_W-1:0]),
        .therm_q(therm_q), .bin_q(bin_q)
    );

    // rebuild: count of lit lines times the segment weight, plus binary part
    always_comb begin
        ones = '0;
        for (int i = 0; i < THERM_W; i++)
            ones = ones + SEG_BITS'(therm_q[i]);
    end
    assign code_chk = {ones, bin_q};

    a_r1_rebuild: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (code_chk == $past(code_in ^ {DATA_W{invert}})));

    a_r4_therm_shape: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (((therm_q + 1'b1) & therm_q) == '0));

    a_r9_reset_zero: assert property (@(posedge clk)
        !rst_n |-> (therm_q == '0 && bin_q == '0));
endmodule

// File: tb/sdac_input_decoder_test.sv
module sdac_input_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] code_in = 8'h00;
    logic       invert = 1'b0;
    logic       load_n = 1'b1;
    logic [6:0] therm_q;
    logic [4:0] bin_q;
    logic [7:0] code_chk;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sdac_input_decoder uut (
        .clk(clk), .rst_n(rst_n), .code_in(code_in), .invert(invert),
        .load_n(load_n), .therm_q(therm_q), .bin_q(bin_q), .code_chk(code_chk)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int therm_of(input int v);
        return (1 << (v >> 5)) - 1;
    endfunction

    task automatic check_outs(input string req, input int v);
        chk({req, " therm R4"}, int'(therm_q), therm_of(v));
        chk({req, " bin R5"}, int'(bin_q), v & 31);
        chk({req, " rebuild R1"}, int'(code_chk), v);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        chk("R9 reset therm", int'(therm_q), 0);
        chk("R9 reset bin", int'(bin_q), 0);
        chk("R9 reset chk", int'(code_chk), 0);
        rst_n = 1'b1;

        // sweep: all codes, both invert settings
        for (int inv = 0; inv < 2; inv++) begin
            for (int c = 0; c < 256; c++) begin
                @(negedge clk);
                code_in = 8'(c); invert = inv[0]; load_n = 1'b0;
                @(negedge clk);
                if (inv == 0) check_outs("R2", c);
                else          check_outs("R3", 255 - c);
            end
        end

        // R6: no change before the edge
        @(negedge clk);
        code_in = 8'h5A; invert = 1'b0; load_n = 1'b0;
        @(negedge clk);
        code_in = 8'hC3;
        #2 chk("R6 before edge", int'(code_chk), 8'h5A);
        @(negedge clk);
        chk("R6 after edge", int'(code_chk), 8'hC3);

        // R7: hold ignores code and invert
        load_n = 1'b1;
        held = 8'hC3;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            code_in = 8'(k * 37 + 1); invert = k[0];
            @(negedge clk);
            check_outs("R7 hold", held);
        end

        // R8: strobe rises together with a new code
        @(negedge clk);
        code_in = 8'h81; invert = 1'b0; load_n = 1'b0;
        @(negedge clk);
        code_in = 8'h3E; load_n = 1'b1;
        @(negedge clk);
        check_outs("R8 capture", 8'h81);
        @(negedge clk);
        check_outs("R8 keep", 8'h81);

        // R9: reset while holding
        rst_n = 1'b0;
        #2;
        chk("R9 async clear", int'(code_chk), 0);
        @(negedge clk);
        chk("R9 therm", int'(therm_q), 0);
        chk("R9 bin", int'(bin_q), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 held after reset", int'(code_chk), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule